// File: doc/BRIEF.md
# Mobile Link Controller with Frame Spreader

This block runs the handset side of a spread-spectrum link session and produces the serial chip stream for every frame it sends. When the power switch turns on, it asks the network for a channel with a request frame. It then waits for an acknowledge event from the receive path, and sends the request again if none arrives within a set number of idle cycles. Once the acknowledge is seen, it enters communication mode, lights the link LED and accepts key presses. Each key press is sent as a data frame. Echoed data reported by the receive path goes to a display register. When the switch turns off, the LED and the display are cleared and a close frame is sent.

Every frame starts with an 8-bit sync pattern, followed by a 4-bit header code and, for key frames only, an 8-bit data byte. All fields are sent most significant bit first. Each bit lasts SF clock cycles. The sync bits go out as plain levels. Every later chip is the frame bit XOR the `code_chip` input for that cycle. The block takes the code stream as an input and leaves code generation, modulation, the receive path and keypad scanning to other blocks.

Top module: `mlink_ctrl`

## Requirements
- R1: After reset, `tx_chip`, `busy`, `link_led`, `disp_valid` and `disp_data` are all 0, and `tx_chip` stays 0 whenever `busy` is low.
- R2: A frame is sync pattern 8'hB4, then a 4-bit header, then 8 data bits for key frames only. Each field is sent MSB first and each bit is held for SF cycles. `busy` is high exactly for the frame's 12×SF or 20×SF cycles and rises the cycle after the frame is started.
- R3: During the sync bits `tx_chip` equals the frame bit. During every header and data bit `tx_chip` equals the frame bit XOR `code_chip` of the same cycle.
- R4: While the session is off and no frame is in flight, `sw_on` high starts a request frame with header 4'h1 and no data field.
- R5: An `ack_seen` pulse while waiting for acknowledge sets `link_led` on the next cycle and enters communication mode.
- R6: While waiting for acknowledge, once ACK_WAIT idle cycles (cycles with `busy` low) have passed since the last request frame ended, the request frame is sent again.
- R7: A `key_stb` pulse in communication mode sends a frame with header 4'h3 followed by `key_data`. Key strobes in any other mode have no effect.
- R8: A key strobe that arrives while a frame is in flight is held in a one-entry buffer and sent as soon as `busy` falls. A strobe that arrives while the buffer is occupied is dropped.
- R9: An `echo_seen` pulse in communication mode loads `echo_data` into `disp_data` and sets `disp_valid` on the next cycle. The pulse has no effect in other modes.
- R10: `sw_on` low in any active mode clears `link_led`, `disp_valid`, `disp_data` and any buffered key on the next cycle. It then sends a close frame with header 4'h4 and no data once `busy` is low. The session does not restart until that frame has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one chip per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_on | input | 1 | User power switch level |
| key_stb | input | 1 | One-cycle key press strobe |
| key_data | input | 8 | Key byte qualified by key_stb |
| ack_seen | input | 1 | Receive path saw an acknowledge frame |
| echo_seen | input | 1 | Receive path saw an echoed send frame |
| echo_data | input | 8 | Data byte of the echoed frame |
| code_chip | input | 1 | Current spreading code chip |
| tx_chip | output | 1 | Serial chip stream out |
| link_led | output | 1 | Link established indicator |
| disp_data | output | 8 | Display byte |
| disp_valid | output | 1 | Display byte is valid |
| busy | output | 1 | A frame is being sent |

## Verification
The bench targets the sync/header boundary, where a design that spreads one chip too early or too late corrupts the ninth bit. It checks the retry window, where an off-by-one timer sends the repeated request a cycle early or late. It drives key strobes during a frame and while the buffer is full; a wrong design either loses the held key or sends a frame with a stale byte. It also turns the switch off during a frame in flight, where a faulty controller would cut the current frame short or fail to queue the close frame. Keys and echoes sent while the link is down must leave the outputs unchanged.

// File: rtl/mlink_pkg.sv
package mlink_pkg;
  localparam int SYNC_W = 8;
  localparam int HDR_W  = 4;
  localparam int DATA_W = 8;
  localparam int FRAME_W = SYNC_W + HDR_W + DATA_W;

  localparam logic [SYNC_W-1:0] SYNC_PAT  = 8'hB4;
  localparam logic [HDR_W-1:0]  HDR_REQ   = 4'h1;
  localparam logic [HDR_W-1:0]  HDR_ACK   = 4'h2;
  localparam logic [HDR_W-1:0]  HDR_SEND  = 4'h3;
  localparam logic [HDR_W-1:0]  HDR_CLOSE = 4'h4;

  typedef enum logic [1:0] {SES_OFF, SES_WAIT, SES_COMM, SES_CLOSE} ses_t;

  // Number of bits in a frame with or without the data field.
  function automatic int frame_len(input logic with_data);
    return with_data ? FRAME_W : (SYNC_W + HDR_W);
  endfunction

  // Bits at index SYNC_W and above are spread.
  function automatic logic spread_on(input int bit_idx);
    return bit_idx >= SYNC_W;
  endfunction

  function automatic logic chip_out(input logic b, input logic spr, input logic code);
    return b ^ (spr & code);
  endfunction
endpackage

// File: rtl/mlink_framer.sv
module mlink_framer
  import mlink_pkg::*;
#(
  parameter int SF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HDR_W-1:0]  hdr,
  input  logic              has_data,
  input  logic [DATA_W-1:0] data,
  input  logic              code_chip,
  output logic              tx_chip,
  output logic              active
);
  localparam int CW = (SF > 1) ? $clog2(SF) : 1;
  localparam int BW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [BW-1:0]      bit_idx;
  logic [BW-1:0]      nbits;
  logic [CW-1:0]      chip_cnt;

  logic chip_last, bit_last, cur_spread;
  assign chip_last  = (chip_cnt == CW'(SF - 1));
  assign bit_last   = (bit_idx == nbits - BW'(1));
  assign cur_spread = spread_on(int'(bit_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      nbits    <= '0;
      chip_cnt <= '0;
    end else if (start && !active) begin
      active   <= 1'b1;
      shreg    <= {SYNC_PAT, hdr, (has_data ? data : {DATA_W{1'b0}})};
      nbits    <= BW'(frame_len(has_data));
      bit_idx  <= '0;
      chip_cnt <= '0;
    end else if (active) begin
      if (chip_last) begin
        chip_cnt <= '0;
        if (bit_last) begin
          active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + BW'(1);
          shreg   <= {shreg[FRAME_W-2:0], 1'b0};
        end
      end else begin
        chip_cnt <= chip_cnt + CW'(1);
      end
    end
  end

  assign tx_chip = active & chip_out(shreg[FRAME_W-1], cur_spread, code_chip);

  AST_CHIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(chip_cnt) < SF)); // R2
  AST_RISE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tx_chip); // R1
endmodule

// File: rtl/mlink_session.sv
module mlink_session
  import mlink_pkg::*;
#(
  parameter int ACK_WAIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_on,
  input  logic              key_stb,
  input  logic [DATA_W-1:0] key_data,
  input  logic              ack_seen,
  input  logic              echo_seen,
  input  logic [DATA_W-1:0] echo_data,
  input  logic              busy,
  output logic              fr_start,
  output logic [HDR_W-1:0]  fr_hdr,
  output logic              fr_has_data,
  output logic [DATA_W-1:0] fr_data,
  output logic              link_led,
  output logic [DATA_W-1:0] disp_data,
  output logic              disp_valid
);
  localparam int TW = $clog2(ACK_WAIT + 1);

  ses_t              state;
  logic [TW-1:0]     timer;
  logic              pend;
  logic [DATA_W-1:0] pbyte;

  // Named events for the checks below.
  logic in_comm, ack_take, timeout_hit, key_take, key_drop, go_down;
  assign in_comm     = (state == SES_COMM) && sw_on;
  assign ack_take    = (state == SES_WAIT) && sw_on && ack_seen;
  assign timeout_hit = (state == SES_WAIT) && sw_on && !ack_seen && !busy && (timer == TW'(ACK_WAIT));
  assign key_take    = in_comm && key_stb && !pend;
  assign key_drop    = in_comm && key_stb && pend;
  assign go_down     = !sw_on && ((state == SES_WAIT) || (state == SES_COMM));

  always_comb begin
    fr_start    = 1'b0;
    fr_hdr      = HDR_REQ;
    fr_has_data = 1'b0;
    fr_data     = pbyte;
    case (state)
      SES_OFF:   fr_start = sw_on && !busy;
      SES_WAIT:  fr_start = timeout_hit;
      SES_COMM: begin
        fr_start    = in_comm && pend && !busy;
        fr_hdr      = HDR_SEND;
        fr_has_data = 1'b1;
      end
      SES_CLOSE: begin
        fr_start = !busy;
        fr_hdr   = HDR_CLOSE;
      end
      default: fr_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SES_OFF;
      timer      <= '0;
      pend       <= 1'b0;
      pbyte      <= '0;
      link_led   <= 1'b0;
      disp_data  <= '0;
      disp_valid <= 1'b0;
    end else begin
      case (state)
        SES_OFF: if (fr_start) begin
          state <= SES_WAIT;
          timer <= '0;
        end
        SES_WAIT: begin
          if (!sw_on) state <= SES_CLOSE;
          else if (ack_take) begin
            state    <= SES_COMM;
            link_led <= 1'b1;
          end else if (!busy) begin
            timer <= timeout_hit ? '0 : timer + TW'(1);
          end
        end
        SES_COMM: begin
          if (!sw_on) state <= SES_CLOSE;
          if (echo_seen && sw_on) begin
            disp_data  <= echo_data;
            disp_valid <= 1'b1;
          end
          if (key_take) begin
            pend  <= 1'b1;
            pbyte <= key_data;
          end else if (fr_start) begin
            pend <= 1'b0;
          end
        end
        SES_CLOSE: if (fr_start) state <= SES_OFF;
        default: state <= SES_OFF;
      endcase
      if (go_down) begin
        link_led   <= 1'b0;
        disp_valid <= 1'b0;
        disp_data  <= '0;
        pend       <= 1'b0;
      end
    end
  end

  AST_LED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    link_led |-> (state == SES_COMM)); // R5
  AST_ACK_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> link_led); // R5
  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SES_OFF) |-> (!link_led && !disp_valid && !pend)); // R10
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    key_drop && !fr_start |=> pend && $stable(pbyte)); // R8
  AST_SEND_ONLY_COMM: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_start && fr_has_data) |-> in_comm); // R7
endmodule

// File: rtl/mlink_ctrl.sv
module mlink_ctrl
  import mlink_pkg::*;
#(
  parameter int SF       = 4,
  parameter int ACK_WAIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_on,
  input  logic       key_stb,
  input  logic [7:0] key_data,
  input  logic       ack_seen,
  input  logic       echo_seen,
  input  logic [7:0] echo_data,
  input  logic       code_chip,
  output logic       tx_chip,
  output logic       link_led,
  output logic [7:0] disp_data,
  output logic       disp_valid,
  output logic       busy
);
  logic              fr_start, fr_has_data;
  logic [HDR_W-1:0]  fr_hdr;
  logic [DATA_W-1:0] fr_data;

  mlink_session #(.ACK_WAIT(ACK_WAIT)) u_ses (
    .clk(clk), .rst_n(rst_n), .sw_on(sw_on),
    .key_stb(key_stb), .key_data(key_data),
    .ack_seen(ack_seen), .echo_seen(echo_seen), .echo_data(echo_data),
    .busy(busy),
    .fr_start(fr_start), .fr_hdr(fr_hdr), .fr_has_data(fr_has_data), .fr_data(fr_data),
    .link_led(link_led), .disp_data(disp_data), .disp_valid(disp_valid)
  );

  mlink_framer #(.SF(SF)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(fr_start), .hdr(fr_hdr),
    .has_data(fr_has_data), .data(fr_data), .code_chip(code_chip),
    .tx_chip(tx_chip), .active(busy)
  );

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_start |-> !busy); // R2
endmodule

// File: tb/sim_mlink_ctrl.sv
module sim_mlink_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SF = 4;
  localparam int ACK_WAIT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_on = 0, key_stb = 0, ack_seen = 0, echo_seen = 0, code_chip = 0;
  logic [7:0] key_data = 0, echo_data = 0;
  logic tx_chip, link_led, disp_valid, busy;
  logic [7:0] disp_data;

  mlink_ctrl #(.SF(SF), .ACK_WAIT(ACK_WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .key_stb(key_stb), .key_data(key_data),
    .ack_seen(ack_seen), .echo_seen(echo_seen), .echo_data(echo_data),
    .code_chip(code_chip), .tx_chip(tx_chip), .link_led(link_led),
    .disp_data(disp_data), .disp_valid(disp_valid), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference model: mode 0 off, 1 wait ack, 2 comm, 3 closing.
  int chips[$];
  int m_mode = 0, m_timer = 0;
  bit m_pend = 0, m_led = 0, m_dv = 0;
  logic [7:0] m_pbyte = 0, m_dd = 0;

  task automatic load_frame(input logic [3:0] h, input bit with_data, input logic [7:0] d);
    logic [19:0] w;
    int n;
    w = {8'hB4, h, d};
    n = with_data ? 20 : 12;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < SF; k++)
        chips.push_back(int'(w[19-i]) | ((i >= 8) ? 2 : 0));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      chips.delete();
      m_mode = 0; m_timer = 0; m_pend = 0; m_led = 0; m_dv = 0; m_pbyte = 0; m_dd = 0;
    end else begin
      bit idle;
      bit go;
      logic [3:0] h;
      bit wd;
      idle = (chips.size() == 0);
      go = 0; h = 4'h1; wd = 0;
      if (!idle) void'(chips.pop_front());
      case (m_mode)
        0: if (sw_on && idle) begin go = 1; m_mode = 1; m_timer = 0; end
        1: begin
          if (!sw_on) begin m_mode = 3; m_led = 0; m_dv = 0; m_dd = 0; m_pend = 0; end
          else if (ack_seen) begin m_mode = 2; m_led = 1; end
          else if (idle) begin
            if (m_timer == ACK_WAIT) begin go = 1; m_timer = 0; end  // R6
            else m_timer++;
          end
        end
        2: begin
          if (!sw_on) begin m_mode = 3; m_led = 0; m_dv = 0; m_dd = 0; m_pend = 0; end
          else begin
            if (echo_seen) begin m_dd = echo_data; m_dv = 1; end
            if (m_pend && idle) begin go = 1; h = 4'h3; wd = 1; end
            if (key_stb && !m_pend) begin m_pend = 1; m_pbyte = key_data; end
            else if (go) m_pend = 0;
          end
        end
        default: if (idle) begin go = 1; h = 4'h4; m_mode = 0; end
      endcase
      if (go) load_frame(h, wd, (h == 4'h3) ? m_pbyte : 8'h00);
    end
  end

  // Code chips change at the falling edge; outputs compared 1 time unit later.
  always @(negedge clk) begin
    cyc++;
    code_chip <= cyc[0] ^ cyc[2] ^ cyc[3];
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic e_tx;
      e_tx = (chips.size() != 0) ? (chips[0][0] ^ (chips[0][1] & code_chip)) : 1'b0;
      vectors++;
      if (tx_chip !== e_tx || busy !== (chips.size() != 0) || link_led !== m_led ||
          disp_valid !== m_dv || disp_data !== m_dd) begin
        miscompares++;
        $display("FAIL %s cyc %0d: tx/busy/led/dv/dd = %b %b %b %b %h, expected %b %b %b %b %h",
                 cur_req, cyc, tx_chip, busy, link_led, disp_valid, disp_data,
                 e_tx, (chips.size() != 0), m_led, m_dv, m_dd);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_key(input logic [7:0] d);
    @(negedge clk); key_stb = 1; key_data = d;
    @(negedge clk); key_stb = 0;
  endtask
  task automatic pulse_ack();
    @(negedge clk); ack_seen = 1;
    @(negedge clk); ack_seen = 0;
  endtask
  task automatic pulse_echo(input logic [7:0] d);
    @(negedge clk); echo_seen = 1; echo_data = d;
    @(negedge clk); echo_seen = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1;
    @(negedge clk); #2;
    vectors++;  // R1 explicit reset state
    if (tx_chip !== 0 || busy !== 0 || link_led !== 0 || disp_valid !== 0 || disp_data !== 0) begin
      miscompares++;
      $display("FAIL R1 reset: tx/busy/led/dv/dd = %b %b %b %b %h, expected 0 0 0 0 00",
               tx_chip, busy, link_led, disp_valid, disp_data);
    end
    cur_req = "R7 R9 (ignored while off)";
    pulse_key(8'h5A); pulse_echo(8'h33); wait_cyc(4);
    cur_req = "R4 R2 R3 (request frame)";
    @(negedge clk); sw_on = 1;
    wait_cyc(50);
    cur_req = "R6 (request retry)";
    wait_cyc(90);
    cur_req = "R5 (acknowledge)";
    pulse_ack(); wait_cyc(70);
    cur_req = "R7 R2 R3 (key frame)";
    pulse_key(8'hC3); wait_cyc(6);
    cur_req = "R8 (held and dropped keys)";
    pulse_key(8'h96); wait_cyc(3);
    pulse_key(8'hFF); wait_cyc(200);
    cur_req = "R9 (echo)";
    pulse_echo(8'h7E); wait_cyc(5);
    cur_req = "R10 (switch off mid frame)";
    pulse_key(8'h11); wait_cyc(10);
    @(negedge clk); sw_on = 0;
    wait_cyc(150);
    cur_req = "R10 R4 (off while waiting)";
    @(negedge clk); sw_on = 1;
    wait_cyc(20);
    @(negedge clk); sw_on = 0;
    pulse_echo(8'h44); pulse_key(8'h22);
    wait_cyc(120);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    finish_run();
  end
endmodule